// File: doc/BRIEF.md
# Sector-Mapped Read Cache

This block is a read-only cache placed between a processor and a slower main memory. Its storage is split into eight large sectors, and each sector holds sixteen consecutive blocks of sixteen words. A sector can hold any region of memory, and the lookup compares all stored sector tags against the incoming address in the same cycle. Every block frame has its own valid bit. The tag therefore names a whole sector, but the data arrives one block at a time, and only when that block is demanded.

The processor presents a word address with a read strobe while `cpu_ready` is high. A hit returns the word one cycle later. A miss drops `cpu_ready` and fetches the addressed block from memory as a sixteen-word burst, one word per acknowledge. The requested word is returned in the cycle after the last acknowledge. When no sector tag matches, a sector is reclaimed: a sector that has never been allocated is taken first, and otherwise a rotating pointer picks the victim. Writes and coherence are not handled.

Top module: `sector_cache`

## Requirements
- R1: A word address is 18 bits. Bits [17:8] form the sector tag, bits [7:4] select the block within the sector, and bits [3:0] select the word within the block.
- R2: After reset, `cpu_ready` is 1, `cpu_valid` is 0 and `mem_req` is 0. Every sector is unallocated and every block is invalid, so the first read of any address misses. This also holds after a reset in mid-operation.
- R3: A read hits only when a stored sector tag matches and the valid bit of the addressed block is set. A read accepted on a hit gives `cpu_valid`=1, `cpu_hit`=1 and the stored word on `cpu_rdata` in the next cycle, and `cpu_ready` stays 1.
- R4: When the sector tag matches but the block is invalid, only that block is fetched. The other blocks of the sector stay invalid, and a later read of one of them misses.
- R5: When no sector tag matches, the lowest-numbered unallocated sector is taken. Once all eight sectors are allocated, a victim pointer is used instead: it starts at sector 0 and advances by one, wrapping, at each such replacement. A reclaimed sector gets the new tag, and all of its blocks become invalid.
- R6: A fill raises `mem_req` in the cycle after the miss is accepted. It presents `mem_addr` = {tag, block, word} with word counting 0 to 15, and each address is held until `mem_ack`. `mem_req` falls after the sixteenth acknowledge. In the next cycle the block reports `cpu_valid`=1 and `cpu_hit`=0, with the requested word on `cpu_rdata`.
- R7: `cpu_ready` is 0 from the cycle after a miss is accepted through the cycle of the last acknowledge. A `cpu_rd` asserted while `cpu_ready` is 0 has no effect: it produces no return and no memory request.
- R8: All eight sectors can hold eight unrelated tags at once, and each of them then hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_rd | input | 1 | Read strobe, taken when `cpu_ready` is 1 |
| cpu_addr | input | 18 | Word address of the read |
| cpu_ready | output | 1 | Cache can take a read this cycle |
| cpu_valid | output | 1 | Returned word is on `cpu_rdata` |
| cpu_hit | output | 1 | Return came from a hit (1) or a fill (0) |
| cpu_rdata | output | 32 | Returned word |
| mem_req | output | 1 | Fill in progress, word requested at `mem_addr` |
| mem_addr | output | 18 | Word address of the current fill beat |
| mem_ack | input | 1 | Memory delivers `mem_rdata` for `mem_addr` |
| mem_rdata | input | 32 | Fill data word |

## Verification
Reads are made in several patterns, and each one separates a different failure. Repeated reads of one word separate cold misses from hits. A neighbouring block under an already present tag separates a block miss from a sector miss. Eight different tags followed by a ninth, and then rereads of the evicted tags, expose the choice of free sector and the order of the rotating victim pointer. A pseudo-random mix over twelve tags and four blocks, with acknowledge gaps and strobes ignored during fills, checks the per-block valid bits against a behavioural model on every clock.

// File: rtl/sc_pkg.sv
// Shared types for the sector cache.
// Assumes: nothing beyond IEEE 1800-2017.
package sc_pkg;
    typedef enum logic {
        FILL_IDLE = 1'b0,
        FILL_BUSY = 1'b1
    } fill_state_t;
endpackage

// File: rtl/sc_directory.sv
// Sector directory: keeps the sector tags, the allocated flags and the
// per-block valid bits. It compares all tags in parallel and picks a victim
// sector (a free one first, otherwise a rotating pointer).
// Assumes: alloc_en and set_en are never high in the same cycle.
module sc_directory #(
    parameter int TAG_W = 10,
    parameter int BLK_W = 4,
    parameter int NSEC  = 8,
    localparam int SEC_W = $clog2(NSEC),
    localparam int NBLK  = 1 << BLK_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TAG_W-1:0] lk_tag,
    input  logic [BLK_W-1:0] lk_blk,
    output logic             tag_hit,
    output logic             blk_hit,
    output logic [SEC_W-1:0] hit_sec,
    output logic [SEC_W-1:0] victim_sec,
    input  logic             alloc_en,
    input  logic [TAG_W-1:0] alloc_tag,
    input  logic             set_en,
    input  logic [SEC_W-1:0] set_sec,
    input  logic [BLK_W-1:0] set_blk
);
    logic [TAG_W-1:0] tag_q   [NSEC];
    logic [NBLK-1:0]  vld_q   [NSEC];
    logic [NSEC-1:0]  alloc_q;
    logic [NSEC-1:0]  match;
    logic [SEC_W-1:0] rr_q;
    logic [SEC_W-1:0] free_idx;
    logic             free_found;

    // Parallel tag comparators, one per sector.
    for (genvar g = 0; g < NSEC; g++) begin : g_cmp
        assign match[g] = alloc_q[g] && (tag_q[g] == lk_tag);
    end

    // Encode the matching sector.
    always_comb begin
        hit_sec = '0;
        for (int i = 0; i < NSEC; i++)
            if (match[i]) hit_sec = SEC_W'(i);
    end

    // Find the lowest-numbered free sector.
    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        for (int i = NSEC - 1; i >= 0; i--)
            if (!alloc_q[i]) begin
                free_found = 1'b1;
                free_idx   = SEC_W'(i);
            end
    end

    assign tag_hit    = |match;
    assign blk_hit    = tag_hit && vld_q[hit_sec][lk_blk];
    assign victim_sec = free_found ? free_idx : rr_q;

    // Directory state: allocation, valid bits and victim pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alloc_q <= '0;
            rr_q    <= '0;
            for (int i = 0; i < NSEC; i++) begin
                vld_q[i] <= '0;
                tag_q[i] <= '0;
            end
        end else begin
            if (alloc_en) begin
                tag_q[victim_sec]   <= alloc_tag;
                vld_q[victim_sec]   <= '0;
                alloc_q[victim_sec] <= 1'b1;
                if (!free_found)
                    rr_q <= (rr_q == SEC_W'(NSEC - 1)) ? '0 : rr_q + SEC_W'(1);
            end
            if (set_en)
                vld_q[set_sec][set_blk] <= 1'b1;
        end
    end
endmodule

// File: rtl/sc_data_store.sv
// Data array holding every word of every block frame, with one write port
// and one registered read port.
// Assumes: reads and writes never target the same word in one cycle.
module sc_data_store #(
    parameter int IDX_W  = 11,
    parameter int DATA_W = 32,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Write the fill word and perform the registered read.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_data;
        if (rd_en) rd_data <= mem[rd_idx];
    end
endmodule

// File: rtl/sc_fill_ctrl.sv
// Block fill sequencer: on start, it requests the 16-word (2^WRD_W) burst of
// one block, counts acknowledges, and keeps the word the processor asked for.
// Assumes: start is only pulsed while busy is low.
module sc_fill_ctrl #(
    parameter int TAG_W  = 10,
    parameter int BLK_W  = 4,
    parameter int WRD_W  = 4,
    parameter int SEC_W  = 3,
    parameter int DATA_W = 32,
    localparam int ADDR_W = TAG_W + BLK_W + WRD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [TAG_W-1:0]  start_tag,
    input  logic [BLK_W-1:0]  start_blk,
    input  logic [WRD_W-1:0]  start_word,
    input  logic [SEC_W-1:0]  start_sec,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              beat,
    output logic              done,
    output logic [SEC_W-1:0]  fill_sec,
    output logic [BLK_W-1:0]  fill_blk,
    output logic [WRD_W-1:0]  fill_word,
    output logic [DATA_W-1:0] want_data
);
    import sc_pkg::*;

    fill_state_t      st_q;
    logic [TAG_W-1:0] tag_q;
    logic [WRD_W-1:0] want_q;

    assign busy     = (st_q == FILL_BUSY);
    assign mem_req  = busy;
    assign mem_addr = {tag_q, fill_blk, fill_word};
    assign beat     = busy && mem_ack;
    assign done     = beat && (&fill_word);

    // Sequence the burst and capture the requested word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= FILL_IDLE;
            tag_q     <= '0;
            fill_blk  <= '0;
            fill_sec  <= '0;
            fill_word <= '0;
            want_q    <= '0;
            want_data <= '0;
        end else if (start) begin
            st_q      <= FILL_BUSY;
            tag_q     <= start_tag;
            fill_blk  <= start_blk;
            fill_sec  <= start_sec;
            want_q    <= start_word;
            fill_word <= '0;
        end else if (beat) begin
            if (fill_word == want_q) want_data <= mem_rdata;
            fill_word <= fill_word + WRD_W'(1);
            if (done) st_q <= FILL_IDLE;
        end
    end
endmodule

// File: rtl/sector_cache.sv
// Sector-mapped read cache top: it looks up the sector directory, serves hits
// from the data array and starts block fills on a miss.
// Assumes: one outstanding read; memory returns burst words in order.
module sector_cache #(
    parameter int TAG_W  = 10,
    parameter int BLK_W  = 4,
    parameter int WRD_W  = 4,
    parameter int NSEC   = 8,
    parameter int DATA_W = 32,
    localparam int ADDR_W = TAG_W + BLK_W + WRD_W,
    localparam int SEC_W  = $clog2(NSEC),
    localparam int IDX_W  = SEC_W + BLK_W + WRD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_rd,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              cpu_ready,
    output logic              cpu_valid,
    output logic              cpu_hit,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    logic [TAG_W-1:0]  a_tag;
    logic [BLK_W-1:0]  a_blk;
    logic [WRD_W-1:0]  a_word;
    logic              tag_hit, blk_hit, busy, beat, done;
    logic              take, hit_take, miss_take;
    logic [SEC_W-1:0]  hit_sec, victim_sec, fill_sec;
    logic [BLK_W-1:0]  fill_blk;
    logic [WRD_W-1:0]  fill_word;
    logic [DATA_W-1:0] ram_q, want_data;
    logic              valid_q, hit_q;

    assign {a_tag, a_blk, a_word} = cpu_addr;
    assign cpu_ready = !busy;
    assign take      = cpu_rd && cpu_ready;
    assign hit_take  = take && blk_hit;
    assign miss_take = take && !blk_hit;

    sc_directory #(.TAG_W(TAG_W), .BLK_W(BLK_W), .NSEC(NSEC)) u_dir (
        .clk(clk), .rst_n(rst_n),
        .lk_tag(a_tag), .lk_blk(a_blk),
        .tag_hit(tag_hit), .blk_hit(blk_hit),
        .hit_sec(hit_sec), .victim_sec(victim_sec),
        .alloc_en(miss_take && !tag_hit), .alloc_tag(a_tag),
        .set_en(done), .set_sec(fill_sec), .set_blk(fill_blk)
    );

    sc_data_store #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_ram (
        .clk(clk),
        .wr_en(beat), .wr_idx({fill_sec, fill_blk, fill_word}), .wr_data(mem_rdata),
        .rd_en(hit_take), .rd_idx({hit_sec, a_blk, a_word}), .rd_data(ram_q)
    );

    sc_fill_ctrl #(.TAG_W(TAG_W), .BLK_W(BLK_W), .WRD_W(WRD_W),
                   .SEC_W(SEC_W), .DATA_W(DATA_W)) u_fill (
        .clk(clk), .rst_n(rst_n),
        .start(miss_take), .start_tag(a_tag), .start_blk(a_blk),
        .start_word(a_word), .start_sec(tag_hit ? hit_sec : victim_sec),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr),
        .beat(beat), .done(done), .fill_sec(fill_sec), .fill_blk(fill_blk),
        .fill_word(fill_word), .want_data(want_data)
    );

    // Register the return strobe and its source (hit or fill).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            hit_q   <= 1'b0;
        end else begin
            valid_q <= hit_take || done;
            if (hit_take)  hit_q <= 1'b1;
            else if (done) hit_q <= 1'b0;
        end
    end

    assign cpu_valid = valid_q;
    assign cpu_hit   = valid_q && hit_q;
    assign cpu_rdata = hit_q ? ram_q : want_data;
endmodule

// File: rtl/sc_checker.sv
// Port-level protocol checks for sector_cache, attached with bind.
// Assumes: the default field widths of the top module.
module sc_checker #(
    parameter int ADDR_W = 18,
    parameter int WRD_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_rd,
    input logic              cpu_ready,
    input logic              cpu_valid,
    input logic              cpu_hit,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ack
);
    // R2: reset leaves the block idle and quiet.
    a_r2_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (cpu_ready && !cpu_valid && !mem_req));

    // R3: a hit return follows an accepted read by one cycle.
    a_r3_hit_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && cpu_hit) |-> $past(cpu_rd && cpu_ready));

    // R6: a pending beat keeps its address.
    a_r6_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R6: beats walk the block word by word.
    a_r6_word_order: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && (mem_addr[WRD_W-1:0] != '1))
        |=> (mem_req && (mem_addr == $past(mem_addr) + ADDR_W'(1))));

    // R6: the last beat ends the fill and returns the word.
    a_r6_fill_end: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && (mem_addr[WRD_W-1:0] == '1))
        |=> (!mem_req && cpu_valid && !cpu_hit));

    // R7: no reads are taken while a fill runs.
    a_r7_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !cpu_ready);
endmodule

bind sector_cache sc_checker #(.ADDR_W(ADDR_W), .WRD_W(WRD_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .cpu_ready(cpu_ready),
    .cpu_valid(cpu_valid), .cpu_hit(cpu_hit), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ack(mem_ack)
);

// File: tb/sim_sector_cache.sv
// Bench for sector_cache: a behavioural directory model predicts every cycle.
module sim_sector_cache;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_rd = 1'b0;
    logic [17:0] cpu_addr = '0;
    logic        cpu_ready, cpu_valid, cpu_hit, mem_req;
    logic [31:0] cpu_rdata;
    logic [17:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    int total = 0;
    int bad = 0;

    // Behavioural model state.
    int mtag [8];
    bit malloc [8];
    bit mvalid [8][16];
    int rr = 0;

    always #10 clk = ~clk;

    sector_cache u0 (
        .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .cpu_addr(cpu_addr),
        .cpu_ready(cpu_ready), .cpu_valid(cpu_valid), .cpu_hit(cpu_hit),
        .cpu_rdata(cpu_rdata), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] memval(logic [17:0] a);
        return ({14'h0, a} * 32'h9E3779B1) ^ 32'h5AC3_0F1E;
    endfunction

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cmp(string rq, bit rdy, bit vld, bit hit, logic [31:0] dat,
                       bit req, logic [17:0] ma);
        chk({rq, " cpu_ready"}, 32'(cpu_ready), 32'(rdy));
        chk({rq, " cpu_valid"}, 32'(cpu_valid), 32'(vld));
        if (vld) begin
            chk({rq, " cpu_hit"}, 32'(cpu_hit), 32'(hit));
            chk({rq, " cpu_rdata"}, cpu_rdata, dat);
        end
        chk({rq, " mem_req"}, 32'(mem_req), 32'(req));
        if (req) chk({rq, " mem_addr"}, 32'(mem_addr), 32'(ma));
    endtask

    task automatic model_clear();
        for (int i = 0; i < 8; i++) begin
            malloc[i] = 0;
            mtag[i] = 0;
            for (int b = 0; b < 16; b++) mvalid[i][b] = 0;
        end
        rr = 0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cpu_rd = 1'b0;
        mem_ack = 1'b0;
        repeat (3) cyc();
        rst_n = 1'b1;
        model_clear();
        cyc();
        cmp("R2", 1, 0, 0, 0, 0, 0);
    endtask

    // One read; rq names the requirement the return is checked against.
    task automatic do_read(logic [17:0] a, string rq);
        int tag = int'(a[17:8]);
        int blk = int'(a[7:4]);
        int s = -1;
        bit is_hit;
        logic [17:0] base;
        for (int i = 0; i < 8; i++)
            if (malloc[i] && mtag[i] == tag) s = i;
        is_hit = (s >= 0) && mvalid[s][blk];
        cpu_rd = 1'b1;
        cpu_addr = a;
        cyc();
        cpu_rd = 1'b0;
        if (is_hit) begin
            cmp(rq, 1, 1, 1, memval(a), 0, 0);
        end else begin
            if (s < 0) begin
                for (int i = 7; i >= 0; i--) if (!malloc[i]) s = i;
                if (s < 0) begin
                    s = rr;
                    rr = (rr + 1) % 8;
                end
                mtag[s] = tag;
                malloc[s] = 1;
                for (int b = 0; b < 16; b++) mvalid[s][b] = 0;
            end
            base = {a[17:4], 4'h0};
            cmp(rq, 0, 0, 0, 0, 1, base);
            for (int w = 0; w < 16; w++) begin
                if (w % 5 == 2) begin
                    for (int g = 0; g < 2; g++) begin
                        cpu_rd = 1'b1;
                        cpu_addr = a ^ 18'h00110;
                        cyc();
                        cpu_rd = 1'b0;
                        cmp("R7", 0, 0, 0, 0, 1, base + 18'(w));
                    end
                end
                mem_ack = 1'b1;
                mem_rdata = memval(base + 18'(w));
                cyc();
                mem_ack = 1'b0;
                mem_rdata = '0;
                if (w < 15) cmp("R6", 0, 0, 0, 0, 1, base + 18'(w + 1));
                else        cmp("R6", 1, 1, 0, memval(a), 0, 0);
            end
            mvalid[s][blk] = 1;
        end
        cyc();
        cmp("R7", 1, 0, 0, 0, 0, 0);
    endtask

    function automatic logic [17:0] mk(int tag, int blk, int wrd);
        return {10'(tag), 4'(blk), 4'(wrd)};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int seed;
        @(negedge clk);
        do_reset();
        // R2: cold miss, then R3 hits on the same and a sibling word (R1).
        do_read(mk(1, 2, 5), "R2");
        do_read(mk(1, 2, 5), "R3");
        do_read(mk(1, 2, 12), "R1");
        // R4: new block under a present tag, then a third block still misses.
        do_read(mk(1, 3, 0), "R4");
        do_read(mk(1, 4, 7), "R4");
        do_read(mk(1, 2, 0), "R3");
        do_read(mk(1, 3, 15), "R3");
        // R8: eight tags resident at once.
        for (int t = 2; t <= 8; t++) do_read(mk(t, 0, t), "R8");
        for (int t = 1; t <= 8; t++) do_read(mk(t, t == 1 ? 2 : 0, 1), "R8");
        // R5: replacement order through the rotating pointer.
        do_read(mk(9, 1, 1), "R5");
        do_read(mk(1, 2, 5), "R5");
        do_read(mk(2, 0, 3), "R5");
        do_read(mk(4, 0, 4), "R5");
        // R1: extreme field values.
        do_read(mk(1023, 15, 15), "R1");
        do_read(mk(1023, 15, 0), "R1");
        // R2: reset mid-run forgets everything.
        do_reset();
        do_read(mk(4, 0, 4), "R2");
        // Mixed traffic.
        seed = 7;
        for (int i = 0; i < 150; i++) begin
            seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
            do_read(mk((seed >> 8) % 12, (seed >> 4) & 3, seed & 15), "R3");
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule